// File: doc/BRIEF.md
# Reload Timer with Programmable Waveform Output

This block is a down-counting timer whose pin output is driven from a software-held level bit. A reload register holds the period. A prescaler picks the count rate, either a power-of-two division of the main clock or a tick from a slower sub clock. Each time the counter passes zero it reloads from the reload register, emits a one-cycle interrupt pulse and copies the level bit onto the pin. Software writes a new level, and if it wants a new reload value, after each interrupt, and in this way builds an arbitrary waveform one segment at a time.

The block is programmed through a byte-wide register port. Address 0 holds the mode byte, address 1 holds the control byte, and the following addresses hold the counter data bytes, least significant first. A bit in the mode byte decides whether a data write loads the counter at once or only the reload register. In the second case the counter takes up the new value at its next reload. When the mode field does not select waveform operation, the pin output enable drops and the pin is left to ordinary port logic.

Top module: `wave_reload_timer`

## Requirements
- R1: After reset the mode and control bytes read 0, the counter and reload register hold all ones, `pin_oe`, `pin_out` and `irq` are 0, and the write mode is "counter and reload together".
- R2: The block is active only when mode bits [2:0] equal 3'b100 and mode bit 7 is 0. `pin_oe` is 1 exactly while the block is active. Any other mode value, including 3'b000, releases the pin.
- R3: While the block is active and control bit 7 (run) is 1, the counter decrements by one on each count-source tick. Otherwise it holds its value.
- R4: A tick that finds the counter at zero reloads it from the reload register, and `irq` is 1 for the single cycle after that clock edge.
- R5: At each reload `pin_out` takes mode bit 4 (level). It changes at no other time.
- R6: Control bits [3:0] select the count source. A value k from 0 to 9 ticks once every 2^(k+1) main clocks. The value 10 uses `sub_tick`. Values 11 to 15 produce no ticks.
- R7: Data byte address 2 is the low byte and address 3 the high byte. The high-byte write commits both bytes. With mode bit 3 at 0 it loads the reload register and the counter together, and it takes priority over a tick in the same cycle, so no reload occurs in that cycle.
- R8: With mode bit 3 at 1 a committed write loads only the reload register, and the counter takes the value at its next reload. If the write and a reload happen in the same cycle, the reload uses the previous value.
- R9: Reads return the mode byte at address 0, the control byte at address 1 and the live counter bytes at addresses 2 and 3. The reload register cannot be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle sub clock tick, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | One-cycle pulse on each reload |
| pin_out | output | 1 | Waveform pin level |
| pin_oe | output | 1 | Pin output enable, high in waveform mode |

## Verification
The checker runs on every cycle. It confirms that an interrupt only follows a counting tick, that the pin moves only together with an interrupt and then carries the level bit, that the counter holds when nothing steps or loads it, that a zero-count tick reloads the reload value, and that a direct write lands in the counter. Other behaviours can only be shown by the bench's scenarios: the exact division periods of the prescaler, the cases where the mode decode releases the pin, the counter readback in place of the reload value, and the ordering in a write-reload collision. The bench shows these by comparing port values against a reference model.

// File: rtl/wt_pkg.sv
package wt_pkg;
   localparam logic [2:0]  OP_WAVE   = 3'b100;
   localparam int unsigned REG_MODE  = 0;
   localparam int unsigned REG_CTRL  = 1;
   localparam int unsigned REG_DATA0 = 2;
   localparam int unsigned RUN_BIT   = 7;

   // mode byte layout, MSB first
   typedef struct packed {
      logic       evt_sel;     // bit 7: must be 0 for waveform operation
      logic [1:0] spare;       // bits 6:5: stored only
      logic       level;       // bit 4: level driven at reload
      logic       latch_only;  // bit 3: 1 = write reload register only
      logic [2:0] op;          // bits 2:0: operating mode
   } mode_t;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
   parameter int unsigned STAGES = 10,
   parameter int unsigned SEL_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sub_tick,
   input  logic [SEL_W-1:0] src_sel,
   output logic             tick
);
   localparam int unsigned NSRC = STAGES + 1;

   if ((1 << SEL_W) < NSRC) begin : g_bad_sel
      $error("wt_prescaler: SEL_W too narrow for STAGES");
   end

   logic [STAGES-1:0] div_q;
   logic [NSRC-1:0]   tick_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + STAGES'(1);
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_tap
      assign tick_vec[k] = &div_q[k:0];
   end
   assign tick_vec[STAGES] = sub_tick;

   always_comb begin
      tick = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (src_sel == SEL_W'(i)) tick = tick_vec[i];
      end
   end
endmodule

// File: rtl/wt_regs.sv
module wt_regs import wt_pkg::*; #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [CNT_W-1:0]  count,
   output mode_t             mode_q,
   output logic [7:0]        ctrl_q,
   output logic [CNT_W-1:0]  latch_q,
   output logic              direct_load,
   output logic [CNT_W-1:0]  load_value,
   output logic [7:0]        rdata
);
   localparam int unsigned NB   = CNT_W / 8;
   localparam int unsigned NH   = NB - 1;
   localparam int unsigned LAST = REG_DATA0 + NB - 1;

   logic [7:0] hold_q [NH];
   logic       commit;

   assign commit = wr_en && (addr == ADDR_W'(LAST));

   always_comb begin
      load_value[CNT_W-1 -: 8] = wdata;
      for (int b = 0; b < NH; b++) load_value[b*8 +: 8] = hold_q[b];
   end

   assign direct_load = commit && !mode_q.latch_only;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         ctrl_q  <= '0;
         latch_q <= '1;
         for (int b = 0; b < NH; b++) hold_q[b] <= '0;
      end else if (wr_en) begin
         if (addr == ADDR_W'(REG_MODE)) mode_q <= mode_t'(wdata);
         if (addr == ADDR_W'(REG_CTRL)) ctrl_q <= wdata;
         for (int b = 0; b < NH; b++) begin
            if (addr == ADDR_W'(REG_DATA0 + b)) hold_q[b] <= wdata;
         end
         if (commit) latch_q <= load_value;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(REG_MODE)) rdata = mode_q;
      if (addr == ADDR_W'(REG_CTRL)) rdata = ctrl_q;
      for (int b = 0; b < NB; b++) begin
         if (addr == ADDR_W'(REG_DATA0 + b)) rdata = count[b*8 +: 8];
      end
   end
endmodule

// File: rtl/wt_core.sv
module wt_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic             tick,
   input  logic             direct_load,
   input  logic [CNT_W-1:0] load_value,
   input  logic [CNT_W-1:0] latch_q,
   input  logic             level,
   output logic [CNT_W-1:0] count_q,
   output logic             irq,
   output logic             pin_q
);
   logic step, at_zero, uflow;

   assign step    = count_en && tick;
   assign at_zero = (count_q == '0);
   assign uflow   = step && at_zero && !direct_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '1;
         irq     <= 1'b0;
         pin_q   <= 1'b0;
      end else begin
         irq <= uflow;
         if (direct_load)  count_q <= load_value;
         else if (uflow)   count_q <= latch_q;
         else if (step)    count_q <= count_q - CNT_W'(1);
         if (uflow) pin_q <= level;
      end
   end
endmodule

// File: rtl/wave_reload_timer.sv
module wave_reload_timer import wt_pkg::*; #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PRE_STAGES = 10,
   parameter int unsigned SEL_W      = 4,
   parameter int unsigned ADDR_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq,
   output logic              pin_out,
   output logic              pin_oe
);
   localparam int unsigned NB = CNT_W / 8;

   if (CNT_W % 8 != 0 || NB < 2) begin : g_bad_width
      $error("wave_reload_timer: CNT_W must be a multiple of 8, at least 16");
   end
   if ((1 << ADDR_W) < REG_DATA0 + NB) begin : g_bad_addr
      $error("wave_reload_timer: ADDR_W too narrow for the register map");
   end
   if (SEL_W > RUN_BIT) begin : g_bad_sel
      $error("wave_reload_timer: SEL_W overlaps the run bit");
   end

   mode_t            mode_q;
   logic [7:0]       ctrl_q;
   logic [CNT_W-1:0] latch_q, load_value, count_q;
   logic             direct_load, tick, active, count_en, level_bit;

   assign active    = (mode_q.op == OP_WAVE) && !mode_q.evt_sel;
   assign count_en  = active && ctrl_q[RUN_BIT];
   assign level_bit = mode_q.level;
   assign pin_oe    = active;

   wt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .count(count_q), .mode_q(mode_q), .ctrl_q(ctrl_q), .latch_q(latch_q),
      .direct_load(direct_load), .load_value(load_value), .rdata(rdata)
   );

   wt_prescaler #(.STAGES(PRE_STAGES), .SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
      .src_sel(ctrl_q[SEL_W-1:0]), .tick(tick)
   );

   wt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .count_en(count_en), .tick(tick),
      .direct_load(direct_load), .load_value(load_value), .latch_q(latch_q),
      .level(level_bit), .count_q(count_q), .irq(irq), .pin_q(pin_out)
   );
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic             pin_out,
   input logic             count_en,
   input logic             tick,
   input logic             direct_load,
   input logic [CNT_W-1:0] load_value,
   input logic [CNT_W-1:0] latch_q,
   input logic [CNT_W-1:0] count_q,
   input logic             level_bit
);
   // R4
   irq_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(count_en && tick));

   // R4
   reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && tick && count_q == '0 && !direct_load) |=> (count_q == $past(latch_q)) && irq);

   // R5
   pin_moves_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> irq);

   // R5
   pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pin_out == $past(level_bit));

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(count_en && tick) && !direct_load) |=> $stable(count_q));

   // R7
   direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      direct_load |=> (count_q == $past(load_value)) && !irq);
endmodule

bind wave_reload_timer wt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .pin_out(pin_out),
   .count_en(count_en), .tick(tick), .direct_load(direct_load),
   .load_value(load_value), .latch_q(latch_q), .count_q(count_q),
   .level_bit(level_bit)
);

// File: tb/wave_reload_timer_test.sv
module wave_reload_timer_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0, sub_tick = 0, wr_en = 0;
   logic [1:0] addr = 0;
   logic [7:0] wdata = 0, rdata;
   logic irq, pin_out, pin_oe;

   int n_chk = 0, n_err = 0;
   logic [15:0] m_cnt = 16'hFFFF, m_latch = 16'hFFFF;
   logic [7:0]  m_mode = 0, m_ctrl = 0;
   logic        m_pin = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wave_reload_timer uut (.clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic m_active();
      return (m_mode[2:0] == 3'b100) && !m_mode[7];
   endfunction

   // reference step for one sub tick; returns expected irq
   function automatic logic m_tick();
      if (!(m_active() && m_ctrl[7] && m_ctrl[3:0] == 4'd10)) return 1'b0;
      if (m_cnt == 0) begin
         m_cnt = m_latch;
         m_pin = m_mode[4];
         return 1'b1;
      end
      m_cnt = m_cnt - 1;
      return 1'b0;
   endfunction

   function automatic void m_data(input logic [15:0] v);
      m_latch = v;
      if (!m_mode[3]) m_cnt = v;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic set_mode(input logic [7:0] v);
      wr(2'd0, v); m_mode = v;
   endtask

   task automatic set_ctrl(input logic [7:0] v);
      wr(2'd1, v); m_ctrl = v;
   endtask

   task automatic set_data(input logic [15:0] v);
      wr(2'd2, v[7:0]); wr(2'd3, v[15:8]); m_data(v);
   endtask

   task automatic rd16(output logic [15:0] v);
      addr = 2'd2; #1 v[7:0] = rdata;
      addr = 2'd3; #1 v[15:8] = rdata;
   endtask

   task automatic tick_chk(input string req);
      logic e_irq;
      logic [15:0] c;
      @(negedge clk); sub_tick = 1;
      @(negedge clk); sub_tick = 0;
      e_irq = m_tick();
      check(req, "irq", irq, e_irq);
      check(req, "pin_out", pin_out, m_pin);
      rd16(c);
      check(req, "count", c, m_cnt);
   endtask

   task automatic period(input int exp, input string req);
      int n = 0, guard = 0;
      while (!irq && guard < 2000) begin @(negedge clk); guard++; end
      @(negedge clk); n = 1;
      while (!irq && n < 2000) begin @(negedge clk); n++; end
      check(req, "irq period", n, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] c;
      void'($urandom(32'd4242));
      #(CLK_PERIOD * 3);
      @(negedge clk); rst_n = 1;

      // R1 reset state
      addr = 2'd0; #1 check("R1", "mode", rdata, 8'h00);
      addr = 2'd1; #1 check("R1", "ctrl", rdata, 8'h00);
      rd16(c); check("R1", "count", c, 16'hFFFF);
      check("R1", "pin_oe", pin_oe, 0);
      check("R1", "irq", irq, 0);
      check("R1", "pin_out", pin_out, 0);

      // R1/R7 default write mode loads the counter at once
      set_data(16'h0003);
      rd16(c); check("R1", "count after write", c, 16'h0003);

      set_ctrl(8'h8A);
      addr = 2'd1; #1 check("R9", "ctrl readback", rdata, 8'h8A);
      check("R2", "pin_oe idle", pin_oe, 0);
      tick_chk("R2");            // inactive: no count
      set_mode(8'h14);
      addr = 2'd0; #1 check("R9", "mode readback", rdata, 8'h14);
      check("R2", "pin_oe active", pin_oe, 1);
      for (int i = 0; i < 9; i++) tick_chk("R4");

      // R3 stop
      set_ctrl(8'h0A);
      for (int i = 0; i < 3; i++) tick_chk("R3");
      set_ctrl(8'h8A);
      // R2 event switch and mode 000
      set_mode(8'h94);
      check("R2", "pin_oe evt", pin_oe, 0);
      tick_chk("R2");
      set_mode(8'h00);
      check("R2", "pin_oe 000", pin_oe, 0);
      tick_chk("R2");
      set_mode(8'h04);
      check("R2", "pin_oe back", pin_oe, 1);
      // R6 invalid source
      set_ctrl(8'h8B);
      tick_chk("R6");
      set_ctrl(8'h8A);

      // R8 latch-only write; counter readback not latch (R9)
      set_data(16'h0002);
      set_mode(8'h1C);
      set_data(16'h0007);
      rd16(c); check("R9", "count not latch", c, 16'h0002);
      for (int i = 0; i < 4; i++) tick_chk("R8");

      // R8 collision: counter at zero, latch-only commit with tick
      set_mode(8'h04); set_data(16'h0000);
      set_mode(8'h0C);
      wr(2'd2, 8'h05);
      @(negedge clk); addr = 2'd3; wdata = 8'h00; wr_en = 1; sub_tick = 1;
      @(negedge clk); wr_en = 0; sub_tick = 0;
      check("R8", "collision irq", irq, m_tick());
      m_latch = 16'h0005;
      rd16(c); check("R8", "collision count", c, m_cnt);
      tick_chk("R8");

      // R7 collision: direct write beats tick
      set_mode(8'h04); set_data(16'h0000);
      wr(2'd2, 8'h06);
      @(negedge clk); addr = 2'd3; wdata = 8'h00; wr_en = 1; sub_tick = 1;
      @(negedge clk); wr_en = 0; sub_tick = 0;
      m_data(16'h0006);
      check("R7", "collision irq", irq, 0);
      rd16(c); check("R7", "collision count", c, 16'h0006);

      // random mix (R3 R4 R5 R7 R8)
      for (int it = 0; it < 400; it++) begin
         int r = $urandom % 10;
         if (r == 0) set_mode(8'h04 | 8'(($urandom % 2) << 4) | 8'(($urandom % 2) << 3));
         else if (r == 1) set_data(16'($urandom % 6));
         else tick_chk("R5");
      end

      // R6 divided sources
      set_mode(8'h04); set_data(16'h0002);
      set_ctrl(8'h80); period(6, "R6");
      set_ctrl(8'h82); period(24, "R6");
      set_ctrl(8'h83); period(48, "R6");

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule